// File: doc/BRIEF.md
# Multi-domain clock select and divide unit

This unit picks a source and a division ratio for four clock domains of a small microcontroller: the processor, the USB engine, the interval timer and the capture timer. It also chooses what appears on a test clock output pin. All sources arrive as one-cycle tick pulses sampled on a single fast reference clock: one pulse for each rising edge of the external oscillator, the internal fast oscillator, the slow low-power oscillator and the filtered external clock input. Each domain produces a one-cycle clock enable on that reference clock. The enable is high in the same cycle as the source tick that completes the domain's count.

Each domain holds an active copy of its select and ratio fields. A new setting written on the configuration inputs is taken into the active copy only when the domain's counter wraps, so a period already in progress always finishes with the ratio and source it started with. The processor divider offers power-of-two ratios from 1 to 32, plus 128. The USB domain offers a fixed halving of the fast oscillator, or the external oscillator either halved or undivided. The interval timer has a prescaler of 1 to 4, and one of its sources is the capture timer's enable. The capture timer selects a source with no division.

Top module: `clk_ctl_unit`

## Requirements
- R1: `cpu_src_sel` = 0 makes the processor domain count `fast_tick` pulses, and 1 makes it count `ext_tick` pulses.
- R2: `cpu_div_code` values 0 to 5 give one `cpu_en` for every 2^code selected ticks. Values 6 and 7 both give one for every 128 ticks. `cpu_code_rsvd` is 1 exactly when the field holds 6.
- R3: With `usb_src_sel` = 0, `usb_en` fires on every second `fast_tick` and `usb_half` is ignored. With `usb_src_sel` = 1, it fires on every second `ext_tick` when `usb_half` = 1, and on every `ext_tick` when `usb_half` = 0.
- R4: `cap_src_sel` picks the capture source: 0 external, 1 fast, 2 slow, 3 slow. `cap_en` fires on every selected tick.
- R5: `itmr_src_sel` picks the interval timer source: 0 external, 1 fast, 2 slow, 3 `cap_en`. `itmr_en` fires once for every `itmr_pre`+1 selected ticks.
- R6: With `xtal_owns_pin` = 0, `pin_oe` = 1 and `pin_out` equals the source chosen by `pin_src_sel` in the same cycle: 0 `filt_tick`, 1 `fast_tick`, 2 `slow_tick`, 3 `cpu_en`. With `xtal_owns_pin` = 1, both `pin_oe` and `pin_out` are 0.
- R7: A change to a domain's select or ratio field takes effect only at that domain's next wrap. The running period completes with the old setting.
- R8: A synchronous reset clears every counter and loads the active settings from the configuration inputs. While reset is held, no enable fires unless a source tick is present.
- R9: Each enable is asserted in the same reference cycle as the source tick that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_tick | input | 1 | External oscillator edge pulse |
| fast_tick | input | 1 | Internal fast oscillator edge pulse |
| slow_tick | input | 1 | Low-power slow oscillator edge pulse |
| filt_tick | input | 1 | Filtered external clock input edge pulse |
| cpu_src_sel | input | 1 | Processor source: 0 fast, 1 external |
| cpu_div_code | input | 3 | Processor power-of-two divide code |
| usb_src_sel | input | 1 | USB source: 0 fast/2, 1 external |
| usb_half | input | 1 | Halve external source for USB |
| cap_src_sel | input | 2 | Capture timer source |
| itmr_src_sel | input | 2 | Interval timer source |
| itmr_pre | input | 2 | Interval prescale, divide by value+1 |
| pin_src_sel | input | 2 | Test pin source |
| xtal_owns_pin | input | 1 | External oscillator occupies the pin |
| cpu_en | output | 1 | Processor clock enable |
| usb_en | output | 1 | USB clock enable |
| cap_en | output | 1 | Capture timer clock enable |
| itmr_en | output | 1 | Interval timer clock enable |
| cpu_code_rsvd | output | 1 | Divide code 6 is present |
| pin_out | output | 1 | Test pin value |
| pin_oe | output | 1 | Test pin output enable |

## Verification
Every enable, the pin value and the reserved-code flag depend combinationally on the tick inputs and on counter state that was updated at the previous edge. Each result is therefore due in the same cycle as the stimulus. The bench drives ticks and fields on the falling edge and compares all outputs a quarter period later, before the next rising edge. Its model of counters and active settings advances on that rising edge. As a result, a setting change shows up only after the wrap that the model predicts, and a chained capture-to-interval path is checked in the same cycle.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
   // Index of each source inside a four-way tick vector
   typedef enum logic [1:0] {
      SRC_EXT  = 2'd0,
      SRC_FAST = 2'd1,
      SRC_SLOW = 2'd2,
      SRC_AUX  = 2'd3
   } tsrc_e;
endpackage

// File: rtl/clk_dom_div.sv
// One clock domain: source pick plus wrap counter; settings latched at wrap.
module clk_dom_div #(
   parameter int NSRC  = 2,
   parameter int CNT_W = 1,
   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [CNT_W-1:0] cfg_lim,
   output logic             en_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("clk_dom_div: NSRC must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("clk_dom_div: CNT_W must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] cnt_q;
   logic             tick;
   logic             at_lim;

   if (NSRC == 1) begin : g_single
      assign tick = src_tick[0];
   end else begin : g_mux
      logic [NSRC-1:0] hit;
      for (genvar g = 0; g < NSRC; g++) begin : g_src
         assign hit[g] = src_tick[g] && (sel_q == SEL_W'(g));
      end
      assign tick = |hit;
   end

   assign at_lim = (cnt_q == lim_q);
   assign en_o   = tick && at_lim;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         sel_q <= cfg_sel;
         lim_q <= cfg_lim;
      end else if (tick) begin
         if (at_lim) begin
            cnt_q <= '0;
            sel_q <= cfg_sel;
            lim_q <= cfg_lim;
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/clk_pin_mux.sv
// Test pin source pick with release when the oscillator occupies the pin.
module clk_pin_mux #(
   parameter int NSRC = 4,
   localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic [NSRC-1:0]  src_tick,
   input  logic [SEL_W-1:0] sel,
   input  logic             owned,
   output logic             pin_out,
   output logic             pin_oe
);
   if (NSRC < 2) begin : g_bad_nsrc
      $error("clk_pin_mux: NSRC must be at least 2");
   end

   logic [NSRC-1:0] hit;
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign hit[g] = src_tick[g] && (sel == SEL_W'(g));
   end

   assign pin_oe  = !owned;
   assign pin_out = !owned && (|hit);
endmodule

// File: rtl/clk_ctl_unit.sv
module clk_ctl_unit
   import clk_ctl_pkg::*;
#(
   parameter int CPU_CODE_W    = 3,
   parameter int CPU_EXP_MAX   = 7,
   parameter int CPU_RSVD_CODE = 6,
   parameter int PRE_W         = 2
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  ext_tick,
   input  logic                  fast_tick,
   input  logic                  slow_tick,
   input  logic                  filt_tick,
   input  logic                  cpu_src_sel,
   input  logic [CPU_CODE_W-1:0] cpu_div_code,
   input  logic                  usb_src_sel,
   input  logic                  usb_half,
   input  logic [1:0]            cap_src_sel,
   input  logic [1:0]            itmr_src_sel,
   input  logic [PRE_W-1:0]      itmr_pre,
   input  logic [1:0]            pin_src_sel,
   input  logic                  xtal_owns_pin,
   output logic                  cpu_en,
   output logic                  usb_en,
   output logic                  cap_en,
   output logic                  itmr_en,
   output logic                  cpu_code_rsvd,
   output logic                  pin_out,
   output logic                  pin_oe
);
   localparam int CPU_CNT_W = CPU_EXP_MAX;

   if (CPU_EXP_MAX < 1 || CPU_EXP_MAX >= (1 << CPU_CODE_W)) begin : g_bad_exp
      $error("clk_ctl_unit: CPU_EXP_MAX must fit the divide code");
   end
   if (CPU_RSVD_CODE >= (1 << CPU_CODE_W)) begin : g_bad_rsvd
      $error("clk_ctl_unit: CPU_RSVD_CODE outside the code range");
   end
   if (PRE_W < 1) begin : g_bad_pre
      $error("clk_ctl_unit: PRE_W must be at least 1");
   end

   // Processor: exponent clamps to the top ratio from the reserved code upward
   logic [CPU_CODE_W-1:0]  cpu_n;
   logic [CPU_EXP_MAX:0]   cpu_pow;
   logic [CPU_CNT_W-1:0]   cpu_lim;
   always_comb begin
      cpu_n   = (cpu_div_code >= CPU_CODE_W'(CPU_RSVD_CODE))
                ? CPU_CODE_W'(CPU_EXP_MAX) : cpu_div_code;
      cpu_pow = (CPU_EXP_MAX+1)'(1) << cpu_n;
      cpu_lim = CPU_CNT_W'(cpu_pow - 1'b1);
   end
   assign cpu_code_rsvd = (cpu_div_code == CPU_CODE_W'(CPU_RSVD_CODE));

   clk_dom_div #(.NSRC(2), .CNT_W(CPU_CNT_W)) i_cpu_div (
      .clk     (clk),
      .rst     (rst),
      .src_tick({ext_tick, fast_tick}),
      .cfg_sel (cpu_src_sel),
      .cfg_lim (cpu_lim),
      .en_o    (cpu_en)
   );

   // USB: fast source always halved; external halved on request
   logic usb_lim;
   assign usb_lim = !usb_src_sel || usb_half;

   clk_dom_div #(.NSRC(2), .CNT_W(1)) i_usb_div (
      .clk     (clk),
      .rst     (rst),
      .src_tick({ext_tick, fast_tick}),
      .cfg_sel (usb_src_sel),
      .cfg_lim (usb_lim),
      .en_o    (usb_en)
   );

   // Capture: source pick only, top code repeats the slow source
   logic [3:0] cap_src;
   always_comb begin
      cap_src           = '0;
      cap_src[SRC_EXT]  = ext_tick;
      cap_src[SRC_FAST] = fast_tick;
      cap_src[SRC_SLOW] = slow_tick;
      cap_src[SRC_AUX]  = slow_tick;
   end

   clk_dom_div #(.NSRC(4), .CNT_W(1)) i_cap_div (
      .clk     (clk),
      .rst     (rst),
      .src_tick(cap_src),
      .cfg_sel (cap_src_sel),
      .cfg_lim (1'b0),
      .en_o    (cap_en)
   );

   // Interval timer: auxiliary source is the capture enable
   logic [3:0] itmr_src;
   always_comb begin
      itmr_src           = '0;
      itmr_src[SRC_EXT]  = ext_tick;
      itmr_src[SRC_FAST] = fast_tick;
      itmr_src[SRC_SLOW] = slow_tick;
      itmr_src[SRC_AUX]  = cap_en;
   end

   clk_dom_div #(.NSRC(4), .CNT_W(PRE_W)) i_itmr_div (
      .clk     (clk),
      .rst     (rst),
      .src_tick(itmr_src),
      .cfg_sel (itmr_src_sel),
      .cfg_lim (itmr_pre),
      .en_o    (itmr_en)
   );

   // Test pin
   logic [3:0] pin_src;
   always_comb begin
      pin_src           = '0;
      pin_src[SRC_EXT]  = filt_tick;
      pin_src[SRC_FAST] = fast_tick;
      pin_src[SRC_SLOW] = slow_tick;
      pin_src[SRC_AUX]  = cpu_en;
   end

   clk_pin_mux #(.NSRC(4)) i_pin_mux (
      .src_tick(pin_src),
      .sel     (pin_src_sel),
      .owned   (xtal_owns_pin),
      .pin_out (pin_out),
      .pin_oe  (pin_oe)
   );
endmodule

// File: rtl/clk_ctl_unit_chk.sv
module clk_ctl_unit_chk (
   input logic clk,
   input logic rst,
   input logic ext_tick,
   input logic fast_tick,
   input logic slow_tick,
   input logic xtal_owns_pin,
   input logic cpu_en,
   input logic usb_en,
   input logic cap_en,
   input logic itmr_en,
   input logic pin_out,
   input logic pin_oe
);
   a_r6_pin_released: assert property (@(posedge clk) disable iff (rst)
      xtal_owns_pin |-> (!pin_oe && !pin_out));

   a_r6_pin_driven: assert property (@(posedge clk) disable iff (rst)
      !xtal_owns_pin |-> pin_oe);

   a_r9_cpu_on_tick: assert property (@(posedge clk) disable iff (rst)
      cpu_en |-> (ext_tick || fast_tick));

   a_r3_usb_on_tick: assert property (@(posedge clk) disable iff (rst)
      usb_en |-> (ext_tick || fast_tick));

   a_r4_cap_on_tick: assert property (@(posedge clk) disable iff (rst)
      cap_en |-> (ext_tick || fast_tick || slow_tick));

   a_r5_itmr_on_tick: assert property (@(posedge clk) disable iff (rst)
      itmr_en |-> (ext_tick || fast_tick || slow_tick));
endmodule

bind clk_ctl_unit clk_ctl_unit_chk i_chk (
   .clk          (clk),
   .rst          (rst),
   .ext_tick     (ext_tick),
   .fast_tick    (fast_tick),
   .slow_tick    (slow_tick),
   .xtal_owns_pin(xtal_owns_pin),
   .cpu_en       (cpu_en),
   .usb_en       (usb_en),
   .cap_en       (cap_en),
   .itmr_en      (itmr_en),
   .pin_out      (pin_out),
   .pin_oe       (pin_oe)
);

// File: tb/test_clk_ctl_unit.sv
module test_clk_ctl_unit;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ext_tick = 0, fast_tick = 0, slow_tick = 0, filt_tick = 0;
   logic cpu_src_sel = 0;
   logic [2:0] cpu_div_code = 0;
   logic usb_src_sel = 0, usb_half = 0;
   logic [1:0] cap_src_sel = 0, itmr_src_sel = 0, itmr_pre = 0, pin_src_sel = 0;
   logic xtal_owns_pin = 0;
   logic cpu_en, usb_en, cap_en, itmr_en, cpu_code_rsvd, pin_out, pin_oe;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   clk_ctl_unit i_clk_ctl_unit (
      .clk(clk), .rst(rst),
      .ext_tick(ext_tick), .fast_tick(fast_tick), .slow_tick(slow_tick),
      .filt_tick(filt_tick),
      .cpu_src_sel(cpu_src_sel), .cpu_div_code(cpu_div_code),
      .usb_src_sel(usb_src_sel), .usb_half(usb_half),
      .cap_src_sel(cap_src_sel), .itmr_src_sel(itmr_src_sel),
      .itmr_pre(itmr_pre), .pin_src_sel(pin_src_sel),
      .xtal_owns_pin(xtal_owns_pin),
      .cpu_en(cpu_en), .usb_en(usb_en), .cap_en(cap_en), .itmr_en(itmr_en),
      .cpu_code_rsvd(cpu_code_rsvd), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // Model state per domain: 0 cpu, 1 usb, 2 capture, 3 interval
   int m_cnt [4] = '{0, 0, 0, 0};
   int m_lim [4] = '{0, 0, 0, 0};
   int m_sel [4] = '{0, 0, 0, 0};

   function automatic int want_sel(int d);
      case (d)
         0: return int'(cpu_src_sel);
         1: return int'(usb_src_sel);
         2: return int'(cap_src_sel);
         default: return int'(itmr_src_sel);
      endcase
   endfunction

   function automatic int want_lim(int d);
      case (d)
         0: return (cpu_div_code >= 6) ? 127 : ((1 << cpu_div_code) - 1);
         1: return (usb_src_sel && !usb_half) ? 0 : 1;
         2: return 0;
         default: return int'(itmr_pre);
      endcase
   endfunction

   function automatic logic src_of(int d, int s);
      if (d < 2) return (s == 1) ? ext_tick : fast_tick;
      case (s)
         0: return ext_tick;
         1: return fast_tick;
         2: return slow_tick;
         default: return (d == 2) ? slow_tick : exp_en(2);
      endcase
   endfunction

   function automatic logic exp_en(int d);
      return src_of(d, m_sel[d]) && (m_cnt[d] == m_lim[d]);
   endfunction

   function automatic logic exp_pin();
      if (xtal_owns_pin) return 1'b0;
      case (pin_src_sel)
         2'd0: return filt_tick;
         2'd1: return fast_tick;
         2'd2: return slow_tick;
         default: return exp_en(0);
      endcase
   endfunction

   always @(posedge clk) begin
      for (int d = 0; d < 4; d++) begin
         if (rst) begin
            m_cnt[d] <= 0;
            m_sel[d] <= want_sel(d);
            m_lim[d] <= want_lim(d);
         end else if (src_of(d, m_sel[d])) begin
            if (m_cnt[d] == m_lim[d]) begin
               m_cnt[d] <= 0;
               m_sel[d] <= want_sel(d);
               m_lim[d] <= want_lim(d);
            end else begin
               m_cnt[d] <= m_cnt[d] + 1;
            end
         end
      end
   end

   task automatic chk(string req, string ph, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s (%s) actual=%b expected=%b t=%0t", req, ph, act, exp, $time);
      end
   endtask

   // Inputs were driven at the falling edge; compare before the rising edge.
   task automatic step(string ph);
      #5;
      chk("R2 cpu_en",        ph, cpu_en,        exp_en(0));
      chk("R3 usb_en",        ph, usb_en,        exp_en(1));
      chk("R4 cap_en",        ph, cap_en,        exp_en(2));
      chk("R5 itmr_en",       ph, itmr_en,       exp_en(3));
      chk("R2 cpu_code_rsvd", ph, cpu_code_rsvd, cpu_div_code == 3'd6);
      chk("R6 pin_oe",        ph, pin_oe,        !xtal_owns_pin);
      chk("R6 pin_out",       ph, pin_out,       exp_pin());
      @(negedge clk);
   endtask

   task automatic ticks(logic e, logic f, logic s, logic x);
      ext_tick = e; fast_tick = f; slow_tick = s; filt_tick = x;
   endtask

   int cpu_pulses;

   initial begin
      void'($urandom(32'h0C1C_0D1E));
      @(negedge clk);
      cpu_div_code = 3'd2;
      // R8: reset with no ticks keeps all enables low
      for (int i = 0; i < 3; i++) step("R8 reset");
      rst = 1'b0;

      // R9 / R2: fast ticks every cycle, divide by 4, enable same cycle as 4th tick
      ticks(0, 1, 0, 0);
      cpu_pulses = 0;
      for (int i = 0; i < 12; i++) begin
         if (i == 3 || i == 7) chk("R9 cpu_en on 4th tick", "R9", cpu_en, 1'bx === 1'bx);
         cpu_pulses += int'(exp_en(0));
         step("R9");
      end
      chk("R2 pulses over 12 ticks", "R2", cpu_pulses == 3, 1'b1);

      // R7: change mid period from /8 to /1
      rst = 1'b1; cpu_div_code = 3'd3; step("R8 reload"); rst = 1'b0;
      for (int i = 0; i < 3; i++) step("R7 old ratio");
      cpu_div_code = 3'd0;
      for (int i = 0; i < 10; i++) step("R7 after change");

      // R1: external source only
      cpu_src_sel = 1'b1; cpu_div_code = 3'd1;
      for (int i = 0; i < 20; i++) begin
         ticks(1'(i % 2), 1, 0, 0);
         step("R1 ext source");
      end

      // R2: code 6 behaves as 128 and raises the flag
      cpu_src_sel = 1'b0; cpu_div_code = 3'd6;
      ticks(0, 1, 0, 0);
      for (int i = 0; i < 300; i++) step("R2 code6");

      // R3: three USB modes
      usb_src_sel = 0; usb_half = 0;
      for (int i = 0; i < 8; i++) begin ticks(1, 1, 0, 0); step("R3 fast half"); end
      usb_src_sel = 1; usb_half = 1;
      for (int i = 0; i < 8; i++) begin ticks(1, 0, 0, 0); step("R3 ext half"); end
      usb_half = 0;
      for (int i = 0; i < 8; i++) begin ticks(1, 0, 0, 0); step("R3 ext full"); end

      // R6: pin released, then driven from each source
      xtal_owns_pin = 1;
      for (int i = 0; i < 6; i++) begin ticks(1, 1, 1, 1); step("R6 owned"); end
      xtal_owns_pin = 0;
      for (int s = 0; s < 4; s++) begin
         pin_src_sel = 2'(s);
         for (int i = 0; i < 6; i++) begin ticks(1, 1, 1, 1'(i % 2)); step("R6 sources"); end
      end

      // R4 / R5: capture feeding interval timer with prescale 3
      cap_src_sel = 2'd3; itmr_src_sel = 2'd3; itmr_pre = 2'd2;
      for (int i = 0; i < 40; i++) begin ticks(0, 1, 1'(i % 3 == 0), 0); step("R5 chained"); end

      // Constrained random mix
      for (int i = 0; i < 6000; i++) begin
         ticks(1'($urandom_range(1, 0)), 1'($urandom_range(3, 0) != 0),
               1'($urandom_range(7, 0) == 0), 1'($urandom_range(1, 0)));
         if ($urandom_range(39, 0) == 0) begin
            cpu_src_sel  = 1'($urandom_range(1, 0));
            cpu_div_code = 3'($urandom_range(7, 0));
            usb_src_sel  = 1'($urandom_range(1, 0));
            usb_half     = 1'($urandom_range(1, 0));
            cap_src_sel  = 2'($urandom_range(3, 0));
            itmr_src_sel = 2'($urandom_range(3, 0));
            itmr_pre     = 2'($urandom_range(3, 0));
            pin_src_sel  = 2'($urandom_range(3, 0));
            xtal_owns_pin = ($urandom_range(4, 0) == 0);
         end
         rst = ($urandom_range(499, 0) == 0);
         step(rst ? "R8 random reset" : "random");
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule